// File: doc/BRIEF.md
# Priority Interrupt Controller

The block collects eight level-sensitive interrupt request lines and folds them into one interrupt output toward a processor. Each line can be blocked by its own mask bit. A priority resolver picks the winning line. In fixed-nested mode line 0 ranks highest and line 7 lowest. In rotating mode the line served most recently drops to the lowest rank, so lines of equal standing are served in turn.

The processor answers the interrupt output with an acknowledge pulse. On that edge the block moves the winning line from pending to in-service and latches an 8-bit vector: a programmable base plus the line index. Service ends when the processor writes the end-of-service code to the command address. That write retires the highest-ranked in-service line.

A 2-bit write port configures the block. Address 0 takes commands, address 1 the mask byte, address 2 the mode byte (bit 0 set selects rotating), and address 3 the vector base.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0, vec_o is 0x00, all eight mask bits are set (every line blocked), nothing is in service, the mode is fixed-nested and the vector base is 0x00.
- R2: A line whose bit in the mask byte (address 1, bit i for line i) is 1 never causes irq_o to rise or wins an acknowledge.
- R3: In fixed-nested mode, irq_o rises one clock after an unmasked request appears with nothing in service. An acknowledge then latches vec_o = base + index of the lowest-numbered unmasked requesting line. vec_o changes only on an acknowledge edge.
- R4: The vector base written to address 3 is added to the line index modulo 256.
- R5: An acknowledge while irq_o is 1 places the winning line in service. That line then no longer drives irq_o, even if its request stays high.
- R6: With lines in service, irq_o is 1 only if an unmasked requesting line ranks strictly above every in-service line. A request of equal or lower rank waits.
- R7: Writing 0x20 to address 0 removes the highest-ranked in-service line from service. Any other value written there changes nothing.
- R8: In rotating mode (address 2, bit 0 = 1), the end-of-service write makes the retired line the lowest rank. The ranking then starts from the next line upward, wrapping from 7 to 0. Lines 0 to 7 held high together are therefore served in the order 0,1,...,7,0.
- R9: An acknowledge while irq_o is 0 latches vec_o = base + 7 and leaves the in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Level interrupt requests, bit i is line i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 command, 1 mask, 2 mode, 3 base |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | Interrupt acknowledge pulse from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector latched on the last acknowledge |

## Verification
The hardest situation to reach from the ports is nested service. Several lines must be in service at once while a request of intermediate rank is pending, and the rotating pointer must sit at an arbitrary position. The stimulus gets there by acknowledging a low-ranked line first. It then raises progressively higher lines and acknowledges each one, stacking the in-service set before end-of-service writes peel it back. For rotation, a full request byte is held high across repeated acknowledge and end-of-service pairs. Every pointer position is therefore visited, and the wrap from 7 to 0 is observed.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd2;
  localparam logic [ADDR_W-1:0] A_BASE = 2'd3;
  localparam logic [7:0] EOI_CODE = 8'h20;
endpackage

// File: rtl/pic_rank_pick.sv
// Finds the first set bit, scanning upward from the line after low_i.
module pic_rank_pick #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [IDX_W-1:0]   low_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [IDX_W-1:0]   rank_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    rank_o  = '0;
    for (int k = N_LINES - 1; k >= 0; k--) begin
      logic [IDX_W-1:0] pos;
      pos = low_i + IDX_W'(k) + IDX_W'(1);
      if (vec_i[pos]) begin
        found_o = 1'b1;
        idx_o   = pos;
        rank_o  = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned VEC_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  output logic [N_LINES-1:0] mask_o,
  output logic               rot_o,
  output logic [VEC_W-1:0]   base_o,
  output logic               eoi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      rot_o  <= 1'b0;
      base_o <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_MASK:  mask_o <= N_LINES'(wr_data_i);
        A_MODE:  rot_o  <= wr_data_i[0];
        A_BASE:  base_o <= VEC_W'(wr_data_i);
        default: ;
      endcase
    end
  end

  assign eoi_o = wr_en_i && (wr_addr_i == A_CMD) && (wr_data_i == EOI_CODE);

  // R2
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_MASK) |=> mask_o == N_LINES'($past(wr_data_i)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned VEC_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int unsigned IDX_W = $clog2(N_LINES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LINES - 1);

  logic [N_LINES-1:0] mask, irr_q, isr_q, isr_d, elig;
  logic               rot, eoi;
  logic [VEC_W-1:0]   base;
  logic [IDX_W-1:0]   low_q, low_eff;
  logic               w_found, t_found;
  logic [IDX_W-1:0]   w_idx, w_rank, t_idx, t_rank;
  logic               grant;

  pic_cfg #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mask_o(mask), .rot_o(rot), .base_o(base), .eoi_o(eoi)
  );

  assign low_eff = rot ? low_q : LAST;
  assign elig    = irr_q & ~mask & ~isr_q;

  pic_rank_pick #(.N_LINES(N_LINES)) u_win (
    .vec_i(elig), .low_i(low_eff), .found_o(w_found), .idx_o(w_idx), .rank_o(w_rank)
  );
  pic_rank_pick #(.N_LINES(N_LINES)) u_top (
    .vec_i(isr_q), .low_i(low_eff), .found_o(t_found), .idx_o(t_idx), .rank_o(t_rank)
  );

  assign irq_o = w_found && (!t_found || (w_rank < t_rank));
  assign grant = ack_i && irq_o;

  always_comb begin
    isr_d = isr_q;
    if (eoi && t_found) isr_d[t_idx] = 1'b0;
    if (grant)          isr_d[w_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      low_q <= LAST;
      vec_o <= '0;
    end else begin
      irr_q <= req_i;
      isr_q <= isr_d;
      if (eoi && t_found && rot) low_q <= t_idx;
      if (ack_i) vec_o <= base + (grant ? VEC_W'(w_idx) : VEC_W'(N_LINES - 1));
    end
  end

  // R5
  grant_adds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant && !eoi) |=> $countones(isr_q) == $countones($past(isr_q)) + 1);
  // R7
  eoi_retires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !ack_i && (isr_q != '0)) |=> $countones(isr_q) + 1 == $countones($past(isr_q)));
  // R9
  spurious_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !eoi) |=> $stable(isr_q));
  // R3
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(vec_o));
  // R2
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '1) |-> !irq_o);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic       irq;
  logic [7:0] vec;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_mask = 8'hFF, m_isr = '0, m_req = '0, m_base = '0, m_vec = '0;
  logic       m_rot = 1'b0;
  int         m_low = 7;

  always #5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ack_i(ack), .irq_o(irq), .vec_o(vec)
  );

  function automatic int eff_low();
    return m_rot ? m_low : 7;
  endfunction
  // first set bit scanning up from low+1; 8 when none
  function automatic int pick(logic [7:0] v);
    for (int k = 0; k < 8; k++)
      if (v[(eff_low() + 1 + k) % 8]) return (eff_low() + 1 + k) % 8;
    return 8;
  endfunction
  function automatic int rank(int i);
    return (i - eff_low() - 1 + 16) % 8;
  endfunction
  function automatic logic m_irq();
    int w, t;
    w = pick(m_req & ~m_mask & ~m_isr);
    t = pick(m_isr);
    return (w != 8) && (t == 8 || rank(w) < rank(t));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_req(logic [7:0] r, string tag);
    req = r; m_req = r;
    tick();
    chk(tag, irq, m_irq());
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, string tag);
    int t;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
    case (a)
      2'd0: if (d == 8'h20) begin
        t = pick(m_isr);
        if (t != 8) begin
          m_isr[t] = 1'b0;
          if (m_rot) m_low = t;
        end
      end
      2'd1: m_mask = d;
      2'd2: m_rot = d[0];
      default: m_base = d;
    endcase
    chk(tag, irq, m_irq());
  endtask

  task automatic do_ack(string tag);
    int w;
    if (m_irq()) begin
      w = pick(m_req & ~m_mask & ~m_isr);
      m_isr[w] = 1'b1;
      m_vec = m_base + 8'(w);
    end else m_vec = m_base + 8'd7;
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk(tag, vec, m_vec);
    chk(tag, irq, m_irq());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 vec", vec, 0);
    req = 8'hFF; m_req = 8'hFF;
    tick();
    chk("R1 mask all set", irq, 0);
    set_req(8'h00, "R1");

    // R3 sweep of every request pattern, nested mode
    wr(2'd3, 8'h40, "R4 base");
    wr(2'd1, 8'h00, "R2 unmask");
    for (int p = 1; p < 256; p++) begin
      set_req(8'(p), "R3 irq");
      do_ack("R3 vec");
      wr(2'd0, 8'h20, "R7 eoi");
      set_req(8'h00, "R3 idle");
    end

    // R2 single unmasked line, all others masked
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, ~(8'(1) << i), "R2 mask");
      set_req(~(8'(1) << i), "R2 masked quiet");
      set_req(8'hFF, "R2 one open");
      do_ack("R2 vec");
      wr(2'd0, 8'h20, "R2 eoi");
      set_req(8'h00, "R2 idle");
    end
    wr(2'd1, 8'h00, "R2 unmask");

    // R4 base wrap
    wr(2'd3, 8'hFC, "R4 base");
    set_req(8'h40, "R4 irq");
    do_ack("R4 wrap");
    chk("R4 wrap value", vec, 8'h02);
    wr(2'd0, 8'h20, "R4 eoi");
    set_req(8'h00, "R4 idle");

    // R5/R6 nesting
    set_req(8'h20, "R6 line5");
    do_ack("R5 grant5");
    chk("R5 held request quiet", irq, 0);
    set_req(8'h60, "R6 lower waits");
    chk("R6 lower waits", irq, 0);
    set_req(8'h64, "R6 higher preempts");
    chk("R6 higher preempts", irq, 1);
    do_ack("R6 grant2");
    set_req(8'h65, "R6 line0 preempts");
    do_ack("R6 grant0");
    wr(2'd0, 8'h20, "R7 retire0");
    wr(2'd0, 8'h20, "R7 retire2");
    wr(2'd0, 8'h20, "R7 retire5");
    set_req(8'h00, "R6 idle");

    // R7 other codes ignored
    set_req(8'h08, "R7 line3");
    do_ack("R7 grant3");
    set_req(8'h18, "R7 line4 waits");
    wr(2'd0, 8'h21, "R7 code 21 ignored");
    chk("R7 ignored", irq, 0);
    wr(2'd0, 8'h00, "R7 code 00 ignored");
    wr(2'd0, 8'h20, "R7 eoi");
    chk("R7 eoi frees", irq, 1);
    do_ack("R7 grant4");
    wr(2'd0, 8'h20, "R7 eoi4");
    set_req(8'h00, "R7 idle");

    // R9 spurious acknowledge
    wr(2'd3, 8'h10, "R9 base");
    do_ack("R9 spurious");
    chk("R9 vec", vec, 8'h17);
    set_req(8'h01, "R9 isr untouched");
    chk("R9 isr untouched", irq, 1);
    do_ack("R9 grant0");
    wr(2'd0, 8'h20, "R9 eoi");
    set_req(8'h00, "R9 idle");

    // R8 rotating round robin over full request byte
    wr(2'd2, 8'h01, "R8 rotate");
    set_req(8'hFF, "R8 all");
    for (int n = 0; n < 17; n++) begin
      do_ack("R8 turn");
      chk("R8 order", vec, 8'h10 + 8'(n % 8));
      wr(2'd0, 8'h20, "R8 eoi");
    end
    for (int p = 1; p < 256; p += 7) begin
      set_req(8'(p), "R8 pattern");
      do_ack("R8 pattern vec");
      set_req(8'hFF, "R8 nest");
      do_ack("R8 nest vec");
      wr(2'd0, 8'h20, "R8 eoi a");
      wr(2'd0, 8'h20, "R8 eoi b");
      set_req(8'h00, "R8 idle");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule